// File: doc/BRIEF.md
# Interrupt Coalescing Timer for DMA Completion Events

This block sits between the descriptor-completion events of a set of DMA channels and their interrupt lines. Every completion carries a flag that says whether the descriptor wants an interrupt. Completions without the flag are dropped. A flagged completion does not reach the interrupt line at once. It opens a holding window whose length is a programmable number of microsecond ticks. Every further flagged completion that arrives while the window is open is folded into it. When the window expires, the channel issues a single one-cycle interrupt pulse.

Each channel has its own delay register. A write selects one channel and carries a value that is wider than the register. Values above the largest legal delay are clamped to it. The register contents of every channel can be read back at all times, along with the constant largest delay. A delay of zero turns coalescing off, so each flagged completion pulses the interrupt directly. The microsecond tick comes from a shared timebase and is one clock cycle wide.

Top module: `irq_coalesce_timer`

## Requirements
- R1: After reset every channel's delay reads 0 and no interrupt pulse is driven.
- R2: A write with `cfg_we[c]` high stores `cfg_wdata` into channel c's delay when the value is at most 16383. The value reads back on `delay_rd` bits [c*14 +: 14] from the cycle after the write.
- R3: A written value above 16383 is stored as 16383.
- R4: `max_delay` always reads 16383, which is 2^14-1.
- R5: A completion with `cmpl_valid` low or with `cmpl_irq_req` low opens no window and causes no pulse.
- R6: With a delay of 0, every flagged completion drives `irq_pulse` high for the clock edge at which it is sampled. This holds for back-to-back completions too.
- R7: With a delay of d>0, the first flagged completion arms the window. A tick sampled in the arming cycle is not counted. The pulse appears at the edge where the d-th later tick is sampled, and without ticks it never appears.
- R8: Flagged completions that arrive while a window is open neither restart nor extend it, and they add no further pulse.
- R9: A coalesced interrupt lasts exactly one cycle and closes the window. The next flagged completion opens a fresh window of full length.
- R10: A write to one channel leaves every other channel's delay unchanged. Completions on one channel never pulse another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | NUM_CH | One-hot write strobe, one bit per channel |
| cfg_wdata | input | WDATA_W | Delay value to write, in microseconds |
| delay_rd | output | NUM_CH*DLY_W | Current delay of every channel, channel 0 in the low bits |
| max_delay | output | DLY_W | Largest supported delay, constant |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| cmpl_valid | input | NUM_CH | Descriptor completed on the channel this cycle |
| cmpl_irq_req | input | NUM_CH | Completing descriptor asks for an interrupt |
| irq_pulse | output | NUM_CH | One-cycle interrupt pulse per channel |

## Verification
The bench builds the block with two channels, the default 14-bit delay and a 16-bit write port. The wider write port is what lets the bench write values above 16383 and check the clamp. The second channel is present so that isolation between channels can be seen at the ports. Because the delay keeps its full width, a window at the 16383-tick maximum can be run to completion with a tick every cycle. Short windows with sparse ticks show that the window counts ticks and not clock cycles.

// File: rtl/irq_coalesce_pkg.sv
// Shared types for the interrupt coalescing timer.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_coalesce_pkg;
    // Window state of one channel: idle, or holding a request.
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_HOLD = 1'b1
    } win_state_e;
endpackage

// File: rtl/icx_delay_reg.sv
// Per-channel delay register with write clamping.
// Holds the coalescing delay in microseconds. Writes above the maximum
// are saturated. Assumes WDATA_W >= DLY_W.
module icx_delay_reg #(
    parameter int DLY_W   = 14,
    parameter int WDATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WDATA_W-1:0] wr_data,
    output logic [DLY_W-1:0]   delay_q
);
    localparam int unsigned MAXV = (1 << DLY_W) - 1;
    localparam logic [WDATA_W-1:0] MAX_WIDE = WDATA_W'(MAXV);

    logic [DLY_W-1:0] clamped;

    // Saturate the incoming value to the largest legal delay.
    always_comb begin
        if (wr_data > MAX_WIDE) clamped = DLY_W'(MAXV);
        else                    clamped = wr_data[DLY_W-1:0];
    end

    // Store the delay on a write; reset to zero (coalescing off).
    always_ff @(posedge clk) begin
        if (!rst_n)     delay_q <= '0;
        else if (wr_en) delay_q <= clamped;
    end

    // R3: an over-range write lands as the maximum.
    p_clamp_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data > MAX_WIDE) |=> (delay_q == DLY_W'(MAXV)));

    // R10: without a write strobe the register holds its value.
    p_hold_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(delay_q));
endmodule

// File: rtl/icx_window_ch.sv
// Coalescing window of one channel.
// A flagged completion arms a window of delay_q microsecond ticks. Later
// flagged completions are absorbed. On expiry a one-cycle pulse is issued.
// A delay of zero bypasses the window. Assumes us_tick is one cycle wide.
module icx_window_ch
    import irq_coalesce_pkg::*;
#(
    parameter int DLY_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] delay_q,
    input  logic             us_tick,
    input  logic             cmpl_valid,
    input  logic             cmpl_irq_req,
    output logic             irq_q
);
    localparam int CNT_W = DLY_W + 1;

    win_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             req_ev;
    logic             dly_zero;
    logic             expire;

    // Decode the request and the expiry condition of the open window.
    always_comb begin
        req_ev   = cmpl_valid & cmpl_irq_req;
        dly_zero = (delay_q == '0);
        cnt_nxt  = cnt_q + 1'b1;
        expire   = (st_q == WIN_HOLD) &&
                   (dly_zero || (us_tick && (cnt_nxt >= CNT_W'(delay_q))));
    end

    // Advance the window state, the tick count and the pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WIN_IDLE;
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= expire || (req_ev && (st_q == WIN_IDLE) && dly_zero);
            if (expire) begin
                st_q  <= WIN_IDLE;
                cnt_q <= '0;
            end else if (st_q == WIN_HOLD) begin
                if (us_tick) cnt_q <= cnt_nxt;
            end else if (req_ev && !dly_zero) begin
                st_q  <= WIN_HOLD;
                cnt_q <= '0;
            end
        end
    end

    // R5: with no window open and no flagged completion, nothing fires.
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == WIN_IDLE) && !req_ev) |=> !irq_q);

    // R7: an open window with a non-zero delay needs a tick to expire.
    p_tick_needed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == WIN_HOLD) && !dly_zero && !us_tick) |=> !irq_q);

    // R9: a pulse is never seen while a window is still open.
    p_closed_on_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (st_q == WIN_IDLE));

    // R9: with coalescing on, the pulse lasts a single cycle.
    p_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !dly_zero) |=> !irq_q);
endmodule

// File: rtl/irq_coalesce_timer.sv
// Multi-channel interrupt coalescing timer, top level.
// One delay register and one window per channel, with a shared
// microsecond tick and a shared write data bus.
// Assumes cfg_we is at most one-hot.
module irq_coalesce_timer #(
    parameter int NUM_CH  = 4,
    parameter int DLY_W   = 14,
    parameter int WDATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       cfg_we,
    input  logic [WDATA_W-1:0]      cfg_wdata,
    output logic [NUM_CH*DLY_W-1:0] delay_rd,
    output logic [DLY_W-1:0]        max_delay,
    input  logic                    us_tick,
    input  logic [NUM_CH-1:0]       cmpl_valid,
    input  logic [NUM_CH-1:0]       cmpl_irq_req,
    output logic [NUM_CH-1:0]       irq_pulse
);
    localparam int unsigned MAXV = (1 << DLY_W) - 1;

    // Largest supported delay, fixed by the register width (R4).
    assign max_delay = DLY_W'(MAXV);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [DLY_W-1:0] dly;

        icx_delay_reg #(
            .DLY_W   (DLY_W),
            .WDATA_W (WDATA_W)
        ) u_dly (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we[c]),
            .wr_data (cfg_wdata),
            .delay_q (dly)
        );

        icx_window_ch #(
            .DLY_W (DLY_W)
        ) u_win (
            .clk          (clk),
            .rst_n        (rst_n),
            .delay_q      (dly),
            .us_tick      (us_tick),
            .cmpl_valid   (cmpl_valid[c]),
            .cmpl_irq_req (cmpl_irq_req[c]),
            .irq_q        (irq_pulse[c])
        );

        assign delay_rd[c*DLY_W +: DLY_W] = dly;
    end

    // R1: the reset state drives no interrupt.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_pulse == '0));
endmodule

// File: tb/irq_coalesce_timer_test.sv
`timescale 1ns/1ps
module irq_coalesce_timer_test;
    localparam int NCH = 2;
    localparam int DW  = 14;
    localparam int WW  = 16;
    localparam int MAXD = 16383;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    cfg_we = '0;
    logic [WW-1:0]     cfg_wdata = '0;
    logic [NCH*DW-1:0] delay_rd;
    logic [DW-1:0]     max_delay;
    logic              us_tick = 1'b0;
    logic [NCH-1:0]    cmpl_valid = '0;
    logic [NCH-1:0]    cmpl_irq_req = '0;
    logic [NCH-1:0]    irq_pulse;

    int checks = 0;
    int errors = 0;
    int ch1_pulses = 0;

    irq_coalesce_timer #(.NUM_CH(NCH), .DLY_W(DW), .WDATA_W(WW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .delay_rd(delay_rd), .max_delay(max_delay), .us_tick(us_tick),
        .cmpl_valid(cmpl_valid), .cmpl_irq_req(cmpl_irq_req),
        .irq_pulse(irq_pulse)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock with the given inputs; outputs sampled 1 ns after the edge.
    task automatic cyc(input logic v0, input logic q0, input logic v1, input logic tk);
        cfg_we       = '0;
        cmpl_valid   = {v1, v0};
        cmpl_irq_req = {v1, q0};
        us_tick      = tk;
        @(posedge clk); #1;
        if (irq_pulse[1]) ch1_pulses++;
    endtask

    task automatic wr(input int ch, input int val);
        cmpl_valid = '0; cmpl_irq_req = '0; us_tick = 1'b0;
        cfg_we = '0; cfg_we[ch] = 1'b1; cfg_wdata = WW'(val);
        @(posedge clk); #1;
        cfg_we = '0;
    endtask

    // Run channel 0 for limit cycles with a tick every 'every' cycles.
    task automatic window(input int every, input int limit, input bit extra,
                          output int first, output int count);
        first = -1; count = 0;
        for (int i = 1; i <= limit; i++) begin
            logic tk;
            tk = ((i % every) == 0);
            cyc(extra && (i < 3), 1'b1, 1'b0, tk);
            if (irq_pulse[0]) begin
                count++;
                if (first < 0) first = i;
            end
        end
    endtask

    task automatic t_reset;
        check("R1 ch0 delay", int'(delay_rd[DW-1:0]), 0);
        check("R1 ch1 delay", int'(delay_rd[2*DW-1:DW]), 0);
        check("R1 irq", int'(irq_pulse), 0);
        check("R4 max", int'(max_delay), MAXD);
    endtask

    task automatic t_write;
        wr(0, 5);
        check("R2 ch0 readback", int'(delay_rd[DW-1:0]), 5);
        check("R10 ch1 untouched", int'(delay_rd[2*DW-1:DW]), 0);
        wr(1, MAXD);
        check("R2 exact max", int'(delay_rd[2*DW-1:DW]), MAXD);
        wr(1, 16384);
        check("R3 clamp 16384", int'(delay_rd[2*DW-1:DW]), MAXD);
        wr(1, 40000);
        check("R3 clamp 40000", int'(delay_rd[2*DW-1:DW]), MAXD);
        check("R10 ch0 untouched", int'(delay_rd[DW-1:0]), 5);
        check("R4 max stable", int'(max_delay), MAXD);
    endtask

    task automatic t_zero;
        wr(0, 0);
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1, 1'b1, 1'b0, 1'b0);
            check("R6 back-to-back pulse", int'(irq_pulse[0]), 1);
        end
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        check("R5 unflagged delay0", int'(irq_pulse[0]), 0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        check("R5 flag without valid", int'(irq_pulse[0]), 0);
    endtask

    task automatic t_window;
        int first, count;
        wr(0, 3);
        cyc(1'b1, 1'b1, 1'b0, 1'b1);   // arming cycle, its tick not counted
        check("R7 no pulse on arm", int'(irq_pulse[0]), 0);
        window(1, 12, 1'b1, first, count);
        check("R7 pulse at 3rd tick", first, 3);
        check("R8 merged to one pulse", count, 1);
        // Sparse ticks: every 4 cycles, fire on the 3rd tick = cycle 12.
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        window(4, 20, 1'b0, first, count);
        check("R7 sparse ticks", first, 12);
        check("R9 single pulse", count, 1);
    endtask

    task automatic t_no_tick_and_rearm;
        int first, count;
        wr(0, 2);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        window(1, 10, 1'b0, first, count);
        check("R5 unflagged opens no window", count, 0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        window(1000, 20, 1'b0, first, count);
        check("R7 no ticks no pulse", count, 0);
        window(1, 5, 1'b0, first, count);
        check("R7 late ticks expire", first, 2);
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        window(1, 5, 1'b0, first, count);
        check("R9 rearm full length", first, 2);
    endtask

    task automatic t_indep;
        check("R10 ch1 never pulsed", ch1_pulses, 0);
        wr(1, 1);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        check("R10 ch1 own pulse", int'(irq_pulse[1]), 1);
        check("R10 ch0 quiet", int'(irq_pulse[0]), 0);
    endtask

    task automatic t_max;
        int first, count;
        wr(0, MAXD);
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        window(1, MAXD + 10, 1'b1, first, count);
        check("R7 max window", first, MAXD);
        check("R8 max window one pulse", count, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        t_write();
        t_zero();
        t_window();
        t_no_tick_and_rearm();
        t_indep();
        t_max();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule